// File: doc/BRIEF.md
# Paging Codeword Receive Checker

This block sits behind the bit slicer of a paging receiver. It takes the received bit stream one bit per strobe, with word alignment supplied from outside, and puts each 32-bit codeword together with the first bit received as the most significant. When the last bit of a word arrives, the block checks the word against the BCH(31,21) generator and against even parity. It sorts the word into one of three classes: address, message or idle. For an address word it presents the address field and the call-type code. For a message word it presents the 20-bit payload.

A small mode machine follows message reception. A clean message word starts a message. A clean address word or the fixed idle codeword ends it, and an idle word that ends a running message raises a one-cycle end marker. Error correction, sync-word search and frame counting belong to neighbouring blocks.

Two state machines make up the control. The framing machine has two states. FILL_HUNT waits for alignment. It moves to FILL_BITS on a strobe that carries word_start, and it moves back to FILL_HUNT when the 32nd bit is stored. A strobe with word_start taken in FILL_BITS restarts the word. The message machine also has two states. MODE_OFF moves to MODE_ON on a clean message word. MODE_ON moves back to MODE_OFF on an idle word, which also produces the end marker, or on a clean address word.

Top module: `pcw_rx_checker`

## Requirements
- R1: A strobe (bit_valid high) with word_start high starts a new word, and its bit becomes bit 1. This applies mid-word as well, where the partial word is thrown away. Strobes that arrive while no word is open are ignored.
- R2: A bit is taken only on a clock edge where bit_valid is high, and any number of idle cycles may fall between strobes. Bit 1 is stored as word bit 31 and bit 32 as word bit 0.
- R3: Call the edge that samples bit 32 edge 0. word_done is high for exactly one clock cycle, from edge 1 to edge 2, and it is low at all other times.
- R4: par_err is 1 when the 32 bits of the word hold an odd number of ones, which means bit 32 fails even parity over bits 1 to 31.
- R5: bch_err is 1 when bits 1 to 31, read as a polynomial with bit 1 as x^30, leave a nonzero remainder when divided by x^10+x^9+x^8+x^6+x^5+x^3+1.
- R6: word_class is 2 (idle) when the word equals 0x7A89C197. Otherwise it is 1 (message) when bit 1 is 1, and 0 (address) when bit 1 is 0. The value 3 never appears.
- R7: On an address-class word, addr_field takes bits 2 to 19 (bit 2 as its MSB) and func_code takes bits 20 and 21 (bit 20 as its MSB). The codes 0, 1, 2 and 3 stand for call types A, B, C and D.
- R8: On a message-class word, payload takes bits 2 to 21, with bit 2 as its MSB.
- R9: All result outputs change only together with word_done, and they hold until the next word_done. A word of one class leaves the fields that belong to the other classes unchanged.
- R10: msg_active is set by a message word that has neither error flag. It is cleared by an idle word or by an error-free address word. A word with an error flag leaves msg_active unchanged. msg_active changes in the same cycle as word_done.
- R11: msg_end is high together with word_done when an idle word arrives while msg_active is 1. An idle word that arrives while msg_active is 0 does not raise msg_end.
- R12: Synchronous reset (rst high at a clock edge) throws away any partial word and clears alignment, msg_active and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Bit strobe: bit_in is taken on this edge |
| bit_in | input | 1 | Received codeword bit |
| word_start | input | 1 | With bit_valid: this bit is bit 1 of a word |
| word_done | output | 1 | One-cycle pulse: a word has been checked |
| word_class | output | 2 | 0 address, 1 message, 2 idle |
| bch_err | output | 1 | Nonzero BCH syndrome on the last word |
| par_err | output | 1 | Even-parity failure on the last word |
| addr_field | output | 18 | Address bits 2 to 19 of the last address word |
| func_code | output | 2 | Call type bits 20 and 21 of the last address word |
| payload | output | 20 | Bits 2 to 21 of the last message word |
| msg_active | output | 1 | Message reception in progress |
| msg_end | output | 1 | One-cycle pulse: an idle word ended a message |

## Verification
Assertions check the following on every cycle. The done strobe and the framing strobe never last two cycles. The result fields hold between words. An idle word never carries an error flag. msg_active rises only together with a clean message word. msg_end comes only when the mode was active and is now closed. Only the bench's scenarios can show the parts that depend on the data: the exact bit-to-field mapping, the syndrome polynomial, realignment in the middle of a word, strobes ignored before alignment, and corrupted words that leave the message mode where it was. For these, a behavioural reference model does the polynomial division on integers and is compared with every output on every clock.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        CLS_ADDR = 2'd0,
        CLS_MSG  = 2'd1,
        CLS_IDLE = 2'd2
    } word_cls_t;

    typedef enum logic {
        FILL_HUNT = 1'b0,
        FILL_BITS = 1'b1
    } fill_st_t;

    typedef enum logic {
        MODE_OFF = 1'b0,
        MODE_ON  = 1'b1
    } mode_st_t;

endpackage

// File: rtl/pcw_shift.sv
module pcw_shift
    import pcw_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              word_start,
    output logic [WORD_W-1:0] word_q,
    output logic              word_rdy
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

    fill_st_t         st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FILL_HUNT;
        else     st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FILL_HUNT: if (bit_valid && word_start) st_d = FILL_BITS;
            FILL_BITS: if (bit_valid && !word_start && cnt_q == LAST_POS) st_d = FILL_HUNT;
        endcase
    end

    // datapath: counter, shift register and ready strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            word_q   <= '0;
            word_rdy <= 1'b0;
        end else begin
            word_rdy <= 1'b0;
            if (bit_valid) begin
                if (word_start) begin
                    word_q <= {{(WORD_W-1){1'b0}}, bit_in};
                    cnt_q  <= CNT_W'(1);
                end else if (st_q == FILL_BITS) begin
                    word_q <= {word_q[WORD_W-2:0], bit_in};
                    if (cnt_q == LAST_POS) begin
                        cnt_q    <= '0;
                        word_rdy <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    p_rdy_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        word_rdy |=> !word_rdy);

    p_hunt_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == FILL_HUNT) |-> (cnt_q == '0));

endmodule

// File: rtl/pcw_syndrome.sv
module pcw_syndrome #(
    parameter int              WORD_W   = 32,
    parameter int              CHK_W    = 10,
    parameter logic [CHK_W:0]  GEN_POLY = 11'h769
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [CHK_W-1:0]  syndrome,
    output logic              parity_bad
);

    // serial long division of bits 1..31 (word_i[WORD_W-1:1]) by the generator
    always_comb begin
        logic [CHK_W-1:0] rem;
        logic             fb;
        rem = '0;
        fb  = 1'b0;
        for (int i = WORD_W - 1; i >= 1; i--) begin
            fb  = rem[CHK_W-1];
            rem = {rem[CHK_W-2:0], word_i[i]};
            if (fb) rem = rem ^ GEN_POLY[CHK_W-1:0];
        end
        syndrome = rem;
    end

    assign parity_bad = ^word_i;

endmodule

// File: rtl/pcw_decode.sv
module pcw_decode
    import pcw_pkg::*;
#(
    parameter int              WORD_W  = 32,
    parameter int              CHK_W   = 10,
    parameter int              ADDR_W  = 18,
    parameter int              FUNC_W  = 2,
    parameter logic [WORD_W-1:0] IDLE_CW = 32'h7A89C197
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      word_rdy,
    input  logic [WORD_W-1:0]         word_i,
    input  logic [CHK_W-1:0]          syndrome,
    input  logic                      parity_bad,
    output logic                      word_done,
    output logic [1:0]                word_class,
    output logic                      bch_err,
    output logic                      par_err,
    output logic [ADDR_W-1:0]         addr_field,
    output logic [FUNC_W-1:0]         func_code,
    output logic [ADDR_W+FUNC_W-1:0]  payload,
    output logic                      msg_active,
    output logic                      msg_end
);

    localparam int DATA_W   = ADDR_W + FUNC_W;
    localparam int INFO_TOP = WORD_W - 2;
    localparam int FUNC_TOP = INFO_TOP - ADDR_W;

    mode_st_t  mode_q, mode_d;
    word_cls_t cls_d;
    logic      clean;
    logic      end_d;

    // classification
    always_comb begin
        if (word_i == IDLE_CW)       cls_d = CLS_IDLE;
        else if (word_i[WORD_W-1])   cls_d = CLS_MSG;
        else                         cls_d = CLS_ADDR;
        clean = (syndrome == '0) && !parity_bad;
    end

    // message mode: next state
    always_comb begin
        mode_d = mode_q;
        end_d  = 1'b0;
        if (word_rdy) begin
            unique case (mode_q)
                MODE_OFF: if (clean && cls_d == CLS_MSG) mode_d = MODE_ON;
                MODE_ON: begin
                    if (cls_d == CLS_IDLE) begin
                        mode_d = MODE_OFF;
                        end_d  = 1'b1;
                    end else if (clean && cls_d == CLS_ADDR) begin
                        mode_d = MODE_OFF;
                    end
                end
            endcase
        end
    end

    // message mode: state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode_d;
    end

    assign msg_active = (mode_q == MODE_ON);

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            word_done  <= 1'b0;
            msg_end    <= 1'b0;
            word_class <= CLS_ADDR;
            bch_err    <= 1'b0;
            par_err    <= 1'b0;
            addr_field <= '0;
            func_code  <= '0;
            payload    <= '0;
        end else begin
            word_done <= word_rdy;
            msg_end   <= end_d;
            if (word_rdy) begin
                word_class <= cls_d;
                bch_err    <= (syndrome != '0);
                par_err    <= parity_bad;
                if (cls_d == CLS_ADDR) begin
                    addr_field <= word_i[INFO_TOP -: ADDR_W];
                    func_code  <= word_i[FUNC_TOP -: FUNC_W];
                end
                if (cls_d == CLS_MSG) payload <= word_i[INFO_TOP -: DATA_W];
            end
        end
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!word_done && !$past(rst)) |-> ($stable(word_class) && $stable(bch_err) &&
        $stable(par_err) && $stable(addr_field) && $stable(func_code) &&
        $stable(payload) && $stable(msg_active)));

    p_cls_legal_r6: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (word_class != 2'd3));

    p_idle_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (word_done && word_class == CLS_IDLE) |-> (!bch_err && !par_err));

    p_mode_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_active) |-> (word_done && word_class == CLS_MSG && !bch_err && !par_err));

    p_end_mark_r11: assert property (@(posedge clk) disable iff (rst)
        msg_end |-> (word_done && word_class == CLS_IDLE && !msg_active && $past(msg_active)));

endmodule

// File: rtl/pcw_rx_checker.sv
module pcw_rx_checker #(
    parameter int                WORD_W   = 32,
    parameter int                CHK_W    = 10,
    parameter int                ADDR_W   = 18,
    parameter int                FUNC_W   = 2,
    parameter logic [CHK_W:0]    GEN_POLY = 11'h769,
    parameter logic [WORD_W-1:0] IDLE_CW  = 32'h7A89C197
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bit_valid,
    input  logic                      bit_in,
    input  logic                      word_start,
    output logic                      word_done,
    output logic [1:0]                word_class,
    output logic                      bch_err,
    output logic                      par_err,
    output logic [ADDR_W-1:0]         addr_field,
    output logic [FUNC_W-1:0]         func_code,
    output logic [ADDR_W+FUNC_W-1:0]  payload,
    output logic                      msg_active,
    output logic                      msg_end
);

    logic [WORD_W-1:0] word_q;
    logic              word_rdy;
    logic [CHK_W-1:0]  syndrome;
    logic              parity_bad;

    pcw_shift #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .word_start (word_start),
        .word_q     (word_q),
        .word_rdy   (word_rdy)
    );

    pcw_syndrome #(.WORD_W(WORD_W), .CHK_W(CHK_W), .GEN_POLY(GEN_POLY)) u_synd (
        .word_i     (word_q),
        .syndrome   (syndrome),
        .parity_bad (parity_bad)
    );

    pcw_decode #(
        .WORD_W (WORD_W),
        .CHK_W  (CHK_W),
        .ADDR_W (ADDR_W),
        .FUNC_W (FUNC_W),
        .IDLE_CW(IDLE_CW)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .word_rdy   (word_rdy),
        .word_i     (word_q),
        .syndrome   (syndrome),
        .parity_bad (parity_bad),
        .word_done  (word_done),
        .word_class (word_class),
        .bch_err    (bch_err),
        .par_err    (par_err),
        .addr_field (addr_field),
        .func_code  (func_code),
        .payload    (payload),
        .msg_active (msg_active),
        .msg_end    (msg_end)
    );

endmodule

// File: tb/pcw_rx_checker_tb.sv
module pcw_rx_checker_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic word_start = 1'b0;

    logic        word_done, bch_err, par_err, msg_active, msg_end;
    logic [1:0]  word_class;
    logic [17:0] addr_field;
    logic [1:0]  func_code;
    logic [19:0] payload;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    pcw_rx_checker u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .word_start(word_start), .word_done(word_done), .word_class(word_class),
        .bch_err(bch_err), .par_err(par_err), .addr_field(addr_field),
        .func_code(func_code), .payload(payload), .msg_active(msg_active),
        .msg_end(msg_end)
    );

    // ---------------- helpers ----------------
    function automatic logic [9:0] poly_rem(input logic [30:0] v);
        logic [30:0] t = v;
        for (int d = 30; d >= 10; d--)
            if (t[d]) t = t ^ (31'(11'h769) << (d - 10));
        return t[9:0];
    endfunction

    function automatic logic [31:0] encode(input logic flag, input logic [19:0] info);
        logic [30:0] top = {flag, info, 10'b0};
        logic [30:0] cw  = top | 31'(poly_rem(top));
        return {cw, ^cw};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_cnt = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_pw  = '0;
    bit          m_pend = 0;
    bit          e_done = 0, e_bch = 0, e_par = 0, e_act = 0, e_end = 0;
    int          e_cls = 0;
    logic [17:0] e_addr = '0;
    logic [1:0]  e_func = '0;
    logic [19:0] e_pay  = '0;

    always @(posedge clk) begin
        started = 1;
        e_done = 0;
        e_end  = 0;
        if (rst) begin
            m_cnt = 0; m_acc = '0; m_pend = 0;
            e_bch = 0; e_par = 0; e_act = 0; e_cls = 0;
            e_addr = '0; e_func = '0; e_pay = '0;
        end else begin
            if (m_pend) begin
                bit clean;
                m_pend = 0;
                e_done = 1;
                e_bch  = (poly_rem(m_pw[31:1]) != 0);
                e_par  = ($countones(m_pw) % 2) == 1;
                if (m_pw == 32'h7A89C197) e_cls = 2;
                else                      e_cls = m_pw[31] ? 1 : 0;
                if (e_cls == 0) begin e_addr = m_pw[30:13]; e_func = m_pw[12:11]; end
                if (e_cls == 1) e_pay = m_pw[30:11];
                clean = !e_bch && !e_par;
                if (e_cls == 2) begin
                    if (e_act) e_end = 1;
                    e_act = 0;
                end else if (clean) begin
                    e_act = (e_cls == 1);
                end
            end
            if (bit_valid) begin
                if (word_start) begin
                    m_acc = {31'b0, bit_in};
                    m_cnt = 1;
                end else if (m_cnt > 0) begin
                    m_acc = {m_acc[30:0], bit_in};
                    m_cnt++;
                    if (m_cnt == 32) begin
                        m_pend = 1; m_pw = m_acc; m_cnt = 0;
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk(word_done == e_done, "R3/R1/R2", "word_done", word_done, e_done);
            chk(word_class == 2'(e_cls), "R6", "word_class", word_class, e_cls);
            chk(bch_err == e_bch, "R5", "bch_err", bch_err, e_bch);
            chk(par_err == e_par, "R4", "par_err", par_err, e_par);
            chk(addr_field == e_addr && func_code == e_func, "R7/R9", "addr/func",
                {addr_field, func_code}, {e_addr, e_func});
            chk(payload == e_pay, "R8/R9", "payload", payload, e_pay);
            chk(msg_active == e_act, "R10/R12", "msg_active", msg_active, e_act);
            chk(msg_end == e_end, "R11", "msg_end", msg_end, e_end);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input logic b, input logic st, input int gap);
        bit_valid = 1'b1; bit_in = b; word_start = st;
        @(negedge clk);
        bit_valid = 1'b0; bit_in = 1'b0; word_start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input int gap);
        for (int i = 31; i >= 0; i--) send_bit(w[i], i == 31, (i > 0) ? gap : 0);
        @(negedge clk);   // word_done now visible
    endtask

    localparam logic [31:0] IDLE = 32'h7A89C197;

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!word_done && !msg_active && !msg_end && addr_field == 0 && payload == 0,
            "R12", "reset outputs", {word_done, msg_active, msg_end}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: strobes before alignment are ignored
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 0);
        w = encode(1'b0, {18'h2D5A3, 2'b10});
        send_word(w, 0);
        chk(word_done && word_class == 2'd0 && addr_field == 18'h2D5A3 && func_code == 2'd2,
            "R7 R1", "address word", {addr_field, func_code}, {18'h2D5A3, 2'd2});
        @(negedge clk);
        chk(!word_done, "R3", "done pulse width", word_done, 0);

        // R2/R8/R10: message word with gapped strobes
        send_word(encode(1'b1, 20'hABCDE), 2);
        chk(word_class == 2'd1 && payload == 20'hABCDE && msg_active && addr_field == 18'h2D5A3,
            "R8 R10", "message word", payload, 20'hABCDE);

        // R5: BCH-only error (flip one check bit and the parity bit)
        send_word(encode(1'b1, 20'h12345) ^ 32'h3, 0);
        chk(bch_err && !par_err && msg_active, "R5", "bch error flags", {bch_err, par_err}, 2'b10);

        // R4: parity-only error on an address word, mode stays
        send_word(encode(1'b0, 20'h00F0F) ^ 32'h1, 1);
        chk(par_err && !bch_err && msg_active && word_class == 2'd0, "R4 R10",
            "parity error flags", {bch_err, par_err}, 2'b01);

        // R11/R6: idle ends message
        send_word(IDLE, 0);
        chk(word_class == 2'd2 && msg_end && !msg_active && !bch_err && !par_err,
            "R11 R6", "idle end", {msg_end, msg_active}, 2'b10);
        @(negedge clk);
        chk(!msg_end, "R11", "end pulse width", msg_end, 0);

        // R11: idle while inactive does not mark an end
        send_word(IDLE, 0);
        chk(!msg_end && word_done, "R11", "idle inactive", msg_end, 0);

        // R10: clean address clears mode
        send_word(encode(1'b1, 20'h55555), 0);
        send_word(encode(1'b0, 20'h0AAAA), 0);
        chk(!msg_active, "R10", "address clears mode", msg_active, 0);

        // R1: realignment mid-word
        send_word(encode(1'b1, 20'h77777), 0);
        for (int i = 0; i < 12; i++) send_bit(i[0], i == 0, 0);
        send_word(encode(1'b1, 20'h13579), 0);
        chk(payload == 20'h13579 && !bch_err && !par_err, "R1", "realign", payload, 20'h13579);

        // R12: reset mid-word
        for (int i = 0; i < 10; i++) send_bit(1'b1, i == 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!msg_active && payload == 0 && addr_field == 0, "R12", "mid-word reset", msg_active, 0);
        for (int i = 0; i < 30; i++) send_bit(1'b0, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk(!word_done && word_class == 0, "R12", "alignment cleared", word_done, 0);

        // mixed traffic
        for (int k = 0; k < 60; k++) begin
            int sel = $urandom_range(0, 9);
            if (sel < 2) w = IDLE;
            else         w = encode(sel > 5, 20'($urandom));
            if ($urandom_range(0, 4) == 0) w = w ^ (32'h1 << $urandom_range(0, 31));
            send_word(w, $urandom_range(0, 1));
        end

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule